// File: doc/BRIEF.md
# Video beam position counter

This block keeps track of where the raster beam of a tile-based video display processor is. It holds a 9-bit horizontal count and a 9-bit vertical count. Neither count runs linearly. Each one skips a range of values at a point that depends on the active mode, so that the values software reads line up with fixed positions on screen. The horizontal count moves once per pixel-clock enable. The vertical count moves once per line-start pulse.

From the two counts the block derives the horizontal and vertical blanking flags, and a packed 16-bit position word that a processor can read. A latch input freezes the position word. Software can then read a stable snapshot while the beam keeps moving.

The horizontal width mode selects either 40 cells or 32 cells. The vertical sequence depends on two inputs: the video standard (60 Hz or 50 Hz) and the row-count mode (28 or 30 rows). The display-enable input forces vertical blanking while it is low.

Top module: `beam_pos_counter`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `hc` loads the line-start value of the current width mode (0x00D when `wide_mode`=1, 0x00B when `wide_mode`=0). At the same edge `vc` loads 0 and the latch is released.
- R2: A `line_start` pulse reloads `hc` with the line-start value of the current width mode, even if `pix_en` is also high. When neither input is high, `hc` keeps its value.
- R3: With `wide_mode`=1, each `pix_en` advances `hc` by one. The value after 0x16C is 0x1C9, and 0x1FF wraps to 0x000. After 420 enables from line start, `hc` is back at 0x00D.
- R4: With `wide_mode`=0, the value after 0x127 is 0x1D2. After 342 enables from line start, `hc` is back at 0x00B.
- R5: With `pal_std`=0 (60 Hz), each `line_start` advances `vc` by one, and the value after 0x0EA is 0x1E5. A frame is 262 lines.
- R6: With `pal_std`=1 (50 Hz), the value after 0x10A is 0x1D2 when `tall_mode`=1 (30 rows), and the value after 0x102 is 0x1CA when `tall_mode`=0 (28 rows). A frame is 313 lines.
- R7: On a `line_start` with `vc`=0x1FF, `vc` becomes 0x000. Without `line_start`, `vc` keeps its value.
- R8: While not latched, `hv_word` equals {`vc`[7:0], `hc`[8:1]}, with `vc` in bits 15:8.
- R9: At the first clock edge where `latch_en` is sampled high after being low, the block captures the position word present before that edge. `hv_word` then shows the captured word until `latch_en` is sampled low, which returns it to the live word.
- R10: `hblank` is 1 exactly when `hc` < 0x00A or `hc` >= 0x166 (`wide_mode`=1), or when `hc` < 0x009 or `hc` >= 0x126 (`wide_mode`=0).
- R11: `vblank` is 1 when `disp_en`=0. When `disp_en`=1, `vblank` is 1 exactly when `vc` >= 0x0F0 (`tall_mode`=1) or `vc` >= 0x0E0 (`tall_mode`=0), and `vc` is not 0x1FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable, advances the horizontal count |
| line_start | input | 1 | Line-start pulse, restarts hc and advances vc |
| wide_mode | input | 1 | 1 selects 40-cell width, 0 selects 32-cell width |
| pal_std | input | 1 | 1 selects 50 Hz timing, 0 selects 60 Hz timing |
| tall_mode | input | 1 | 1 selects 30-row mode, 0 selects 28-row mode |
| disp_en | input | 1 | Display enable; 0 forces vblank |
| latch_en | input | 1 | Position-word latch control |
| hc | output | 9 | Horizontal beam count |
| vc | output | 9 | Vertical beam count |
| hv_word | output | 16 | Packed position word, live or latched |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |

## Verification
The bench builds the block with its default jump and threshold parameters and with `BLANK_REG`=0. With `BLANK_REG`=0 the blanking flags are combinational, so they change in the same cycle as the counters, and each cycle's flags can be compared against the counts of that cycle. The default timing points give full 420- and 342-clock lines and full 262- and 313-line frames. This makes every skip, the 9-bit wrap of both counters, both blanking windows and both vblank thresholds reachable within a few thousand cycles.

// File: rtl/beam_pkg.sv
package beam_pkg;
   localparam int BEAM_W = 9;
   localparam int HVW_W  = 16;
   typedef logic [BEAM_W-1:0] beam_t;
   typedef logic [HVW_W-1:0]  hvw_t;
   localparam beam_t BEAM_MAX = '1;
   typedef enum logic [1:0] {
      STD_60       = 2'd0,
      STD_50_SHORT = 2'd1,
      STD_50_TALL  = 2'd2
   } vstd_e;
endpackage

// File: rtl/beam_hcount.sv
module beam_hcount
   import beam_pkg::*;
#(
   parameter beam_t W_FIRST  = 9'h00D,
   parameter beam_t W_LAST   = 9'h16C,
   parameter beam_t W_RESUME = 9'h1C9,
   parameter beam_t N_FIRST  = 9'h00B,
   parameter beam_t N_LAST   = 9'h127,
   parameter beam_t N_RESUME = 9'h1D2
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pix_en,
   input  logic  line_start,
   input  logic  wide,
   output beam_t hc
);
   localparam int    NMODE = 2;
   localparam beam_t FIRST  [0:NMODE-1] = '{N_FIRST,  W_FIRST};
   localparam beam_t LAST   [0:NMODE-1] = '{N_LAST,   W_LAST};
   localparam beam_t RESUME [0:NMODE-1] = '{N_RESUME, W_RESUME};

   beam_t hc_q;
   beam_t step_nxt [0:NMODE-1];

   generate
      for (genvar m = 0; m < NMODE; m++) begin : g_mode
         if (!(FIRST[m] <= LAST[m] && LAST[m] < RESUME[m])) begin : g_bad
            $error("beam_hcount: skip points out of order in mode %0d", m);
         end
         assign step_nxt[m] = (hc_q == LAST[m]) ? RESUME[m] : hc_q + beam_t'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          hc_q <= FIRST[wide];
      else if (line_start) hc_q <= FIRST[wide];
      else if (pix_en)     hc_q <= step_nxt[wide];
   end

   assign hc = hc_q;

   // R3
   h_wide_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !line_start && wide && hc_q == W_LAST) |=> hc_q == W_RESUME);
   // R4
   h_narrow_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !line_start && !wide && hc_q == N_LAST) |=> hc_q == N_RESUME);
   // R2
   h_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> hc_q == ($past(wide) ? W_FIRST : N_FIRST));
   // R2
   h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_en && !line_start) |=> $stable(hc_q));
endmodule

// File: rtl/beam_vcount.sv
module beam_vcount
   import beam_pkg::*;
#(
   parameter beam_t V60_LAST    = 9'h0EA,
   parameter beam_t V60_RESUME  = 9'h1E5,
   parameter beam_t V50S_LAST   = 9'h102,
   parameter beam_t V50S_RESUME = 9'h1CA,
   parameter beam_t V50T_LAST   = 9'h10A,
   parameter beam_t V50T_RESUME = 9'h1D2
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  line_start,
   input  vstd_e std,
   output beam_t vc
);
   localparam int    NSTD = 3;
   localparam beam_t LAST   [0:NSTD-1] = '{V60_LAST,   V50S_LAST,   V50T_LAST};
   localparam beam_t RESUME [0:NSTD-1] = '{V60_RESUME, V50S_RESUME, V50T_RESUME};

   beam_t vc_q;
   beam_t vc_nxt;
   beam_t step_nxt [0:NSTD-1];

   generate
      for (genvar s = 0; s < NSTD; s++) begin : g_std
         if (!(LAST[s] < RESUME[s])) begin : g_bad
            $error("beam_vcount: skip point out of order in standard %0d", s);
         end
         assign step_nxt[s] = (vc_q == LAST[s]) ? RESUME[s] : vc_q + beam_t'(1);
      end
   endgenerate

   always_comb begin
      case (std)
         STD_50_SHORT: vc_nxt = step_nxt[1];
         STD_50_TALL:  vc_nxt = step_nxt[2];
         default:      vc_nxt = step_nxt[0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          vc_q <= '0;
      else if (line_start) vc_q <= vc_nxt;
   end

   assign vc = vc_q;

   // R5
   v60_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && std == STD_60 && vc_q == V60_LAST) |=> vc_q == V60_RESUME);
   // R6
   v50_tall_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && std == STD_50_TALL && vc_q == V50T_LAST) |=> vc_q == V50T_RESUME);
   // R6
   v50_short_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && std == STD_50_SHORT && vc_q == V50S_LAST) |=> vc_q == V50S_RESUME);
   // R7
   v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && vc_q == BEAM_MAX) |=> vc_q == '0);
   // R7
   v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(vc_q));
endmodule

// File: rtl/beam_hvlatch.sv
module beam_hvlatch
   import beam_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic latch_en,
   input  hvw_t live,
   output hvw_t word
);
   logic held_q;
   hvw_t cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         cap_q  <= '0;
      end else begin
         held_q <= latch_en;
         if (latch_en && !held_q) cap_q <= live;
      end
   end

   assign word = held_q ? cap_q : live;

   // R9
   hv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && !held_q) |=> word == $past(live));
   // R9
   hv_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && latch_en) |=> $stable(word));
   // R8
   hv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en |=> word == live);
endmodule

// File: rtl/beam_blank.sv
module beam_blank
   import beam_pkg::*;
#(
   parameter beam_t W_HB_END   = 9'h00A,
   parameter beam_t W_HB_START = 9'h166,
   parameter beam_t N_HB_END   = 9'h009,
   parameter beam_t N_HB_START = 9'h126,
   parameter beam_t VB_TALL    = 9'h0F0,
   parameter beam_t VB_SHORT   = 9'h0E0,
   parameter bit    BLANK_REG  = 1'b0
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wide,
   input  logic  tall,
   input  logic  disp_en,
   input  beam_t hc,
   input  beam_t vc,
   output logic  hblank,
   output logic  vblank
);
   logic  hb_c, vb_c;
   beam_t vb_thr;

   if (!(W_HB_END < W_HB_START && N_HB_END < N_HB_START)) begin : g_bad_h
      $error("beam_blank: horizontal window inverted");
   end
   if (!(VB_SHORT <= VB_TALL && VB_TALL < BEAM_MAX)) begin : g_bad_v
      $error("beam_blank: vertical thresholds out of range");
   end

   assign vb_thr = tall ? VB_TALL : VB_SHORT;
   assign hb_c   = wide ? (hc < W_HB_END || hc >= W_HB_START)
                        : (hc < N_HB_END || hc >= N_HB_START);
   assign vb_c   = !disp_en || (vc >= vb_thr && vc != BEAM_MAX);

   generate
      if (BLANK_REG) begin : g_reg
         logic hb_q, vb_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hb_q <= 1'b0;
               vb_q <= 1'b1;
            end else begin
               hb_q <= hb_c;
               vb_q <= vb_c;
            end
         end
         assign hblank = hb_q;
         assign vblank = vb_q;
         // R11
         vb_off_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !disp_en |=> vblank);
      end else begin : g_comb
         assign hblank = hb_c;
         assign vblank = vb_c;
         // R11
         vb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !disp_en |-> vblank);
         // R10
         hb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hc == '0) |-> hblank);
      end
   endgenerate
endmodule

// File: rtl/beam_pos_counter.sv
module beam_pos_counter
   import beam_pkg::*;
#(
   parameter bit BLANK_REG = 1'b0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pix_en,
   input  logic        line_start,
   input  logic        wide_mode,
   input  logic        pal_std,
   input  logic        tall_mode,
   input  logic        disp_en,
   input  logic        latch_en,
   output logic [8:0]  hc,
   output logic [8:0]  vc,
   output logic [15:0] hv_word,
   output logic        hblank,
   output logic        vblank
);
   beam_t hc_w, vc_w;
   hvw_t  live_w, word_w;
   vstd_e std_w;

   assign std_w = !pal_std ? STD_60 : (tall_mode ? STD_50_TALL : STD_50_SHORT);

   beam_hcount u_hcount (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
      .wide(wide_mode), .hc(hc_w)
   );

   beam_vcount u_vcount (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .std(std_w), .vc(vc_w)
   );

   assign live_w = {vc_w[7:0], hc_w[BEAM_W-1:1]};

   beam_hvlatch u_latch (
      .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .live(live_w), .word(word_w)
   );

   beam_blank #(.BLANK_REG(BLANK_REG)) u_blank (
      .clk(clk), .rst_n(rst_n), .wide(wide_mode), .tall(tall_mode),
      .disp_en(disp_en), .hc(hc_w), .vc(vc_w), .hblank(hblank), .vblank(vblank)
   );

   assign hc      = hc_w;
   assign vc      = vc_w;
   assign hv_word = word_w;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (vc_w == '0 && word_w == live_w));
endmodule

// File: tb/sim_beam_pos_counter.sv
module sim_beam_pos_counter;
   timeunit 1ns;
   timeprecision 100ps;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, pix_en, line_start, wide_mode, pal_std, tall_mode, disp_en, latch_en;
   logic [8:0]  hc, vc;
   logic [15:0] hv_word;
   logic        hblank, vblank;

   beam_pos_counter #(.BLANK_REG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
      .wide_mode(wide_mode), .pal_std(pal_std), .tall_mode(tall_mode),
      .disp_en(disp_en), .latch_en(latch_en), .hc(hc), .vc(vc),
      .hv_word(hv_word), .hblank(hblank), .vblank(vblank)
   );

   typedef struct {
      string       tag;
      string       hv_tag;
      logic [8:0]  hc;
      logic [8:0]  vc;
      logic [15:0] hv;
      logic        hb;
      logic        vb;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad   = 0;

   logic want_wide = 1'b1, want_pal = 1'b0, want_tall = 1'b0;
   logic want_disp = 1'b1, want_latch = 1'b0;

   logic [8:0]  hc_m, vc_m;
   logic        held_m;
   logic [15:0] cap_m;

   function automatic logic [8:0] start_of(logic w);
      return w ? 9'h00D : 9'h00B;
   endfunction

   function automatic logic [8:0] hc_after(logic [8:0] h, logic w);
      if (w && h == 9'h16C)  return 9'h1C9;
      if (!w && h == 9'h127) return 9'h1D2;
      return h + 9'd1;
   endfunction

   function automatic logic [8:0] vc_after(logic [8:0] v, logic p, logic t);
      if (!p && v == 9'h0EA)      return 9'h1E5;
      if (p && t && v == 9'h10A)  return 9'h1D2;
      if (p && !t && v == 9'h102) return 9'h1CA;
      return v + 9'd1;
   endfunction

   task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // driver: applies inputs at the falling edge and queues the state expected after the next rising edge
   task automatic step(logic rst_v, logic pix_v, logic ls_v, string tag);
      exp_t e;
      string t;
      t = tag;
      @(negedge clk);
      rst_n = rst_v; pix_en = pix_v; line_start = ls_v;
      wide_mode = want_wide; pal_std = want_pal; tall_mode = want_tall;
      disp_en = want_disp; latch_en = want_latch;
      if (!rst_v) begin
         hc_m = start_of(want_wide);
         vc_m = 9'h000;
         held_m = 1'b0;
      end else begin
         if (want_latch && !held_m) cap_m = {vc_m[7:0], hc_m[8:1]};
         held_m = want_latch;
         if (ls_v && vc_m == 9'h1FF) t = "R7";
         if (ls_v) begin
            hc_m = start_of(want_wide);
            vc_m = vc_after(vc_m, want_pal, want_tall);
         end else if (pix_v) begin
            hc_m = hc_after(hc_m, want_wide);
         end
      end
      e.tag    = t;
      e.hc     = hc_m;
      e.vc     = vc_m;
      e.hv     = held_m ? cap_m : {vc_m[7:0], hc_m[8:1]};
      e.hv_tag = held_m ? "R9" : "R8";
      e.hb     = want_wide ? (hc_m < 9'h00A || hc_m >= 9'h166)
                           : (hc_m < 9'h009 || hc_m >= 9'h126);
      e.vb     = !want_disp ||
                 (vc_m >= (want_tall ? 9'h0F0 : 9'h0E0) && vc_m != 9'h1FF);
      q.push_back(e);
   endtask

   // monitor: pops one expected item after each rising edge once outputs have settled
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "hc", {7'd0, hc}, {7'd0, e.hc});
            chk(e.tag, "vc", {7'd0, vc}, {7'd0, e.vc});
            chk(e.hv_tag, "hv_word", hv_word, e.hv);
            chk("R10", "hblank", {15'd0, hblank}, {15'd0, e.hb});
            chk("R11", "vblank", {15'd0, vblank}, {15'd0, e.vb});
         end
      end
   end

   initial begin
      #1600000;
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pix_en = 1'b0; line_start = 1'b0; wide_mode = 1'b1;
      pal_std = 1'b0; tall_mode = 1'b0; disp_en = 1'b1; latch_en = 1'b0;
      hc_m = 9'h000; vc_m = 9'h000; held_m = 1'b0; cap_m = 16'h0000;

      // R1: reset in wide mode, then in narrow mode, then wide again
      step(1'b0, 1'b1, 1'b1, "R1");
      want_wide = 1'b0;
      step(1'b0, 1'b0, 1'b0, "R1");
      want_wide = 1'b1;
      step(1'b0, 1'b0, 1'b0, "R1");
      step(1'b1, 1'b0, 1'b0, "R1");

      // R3: full wide line plus a few extra clocks
      step(1'b1, 1'b0, 1'b1, "R2");
      for (int i = 0; i < 425; i++) step(1'b1, 1'b1, 1'b0, "R3");

      // R4: narrow line with gaps in the pixel enable (R2 hold)
      want_wide = 1'b0;
      step(1'b1, 1'b0, 1'b1, "R2");
      begin
         int n;
         n = 0;
         for (int i = 0; n < 346; i++) begin
            step(1'b1, (i % 3) != 2, 1'b0, "R4");
            if ((i % 3) != 2) n++;
         end
      end

      // R2: line start wins over a simultaneous pixel enable
      step(1'b1, 1'b1, 1'b1, "R2");
      step(1'b1, 1'b0, 1'b0, "R2");

      // R5: 60 Hz frame, both row thresholds
      want_pal = 1'b0; want_tall = 1'b0;
      for (int i = 0; i < 140; i++) step(1'b1, 1'b1, 1'b1, "R5");
      want_tall = 1'b1;
      for (int i = 0; i < 140; i++) step(1'b1, 1'b1, 1'b1, "R5");

      // R6: 50 Hz, 30-row then 28-row
      want_pal = 1'b1; want_tall = 1'b1;
      for (int i = 0; i < 320; i++) step(1'b1, 1'b1, 1'b1, "R6");
      want_tall = 1'b0;
      for (int i = 0; i < 320; i++) step(1'b1, 1'b1, 1'b1, "R6");

      // R11: display disabled forces vertical blanking
      want_disp = 1'b0;
      for (int i = 0; i < 30; i++) step(1'b1, 1'b1, (i % 4) == 0, "R11");
      want_disp = 1'b1;

      // R7: vc holds without line start
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, "R7");

      // R9: latch, hold across counting and a line start, release, latch again
      want_latch = 1'b1;
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, i == 10, "R9");
      want_latch = 1'b0;
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, "R9");
      want_latch = 1'b1;
      for (int i = 0; i < 8; i++) step(1'b1, (i % 2) == 0, 1'b0, "R9");
      want_latch = 1'b0;
      step(1'b1, 1'b1, 1'b0, "R8");

      // R10: another wide line to sweep the wide blanking window
      want_wide = 1'b1;
      step(1'b1, 1'b0, 1'b1, "R2");
      for (int i = 0; i < 421; i++) step(1'b1, 1'b1, 1'b0, "R10");

      repeat (3) @(posedge clk);
      #2;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule